// File: doc/BRIEF.md
# Two-Branch Serial-to-Parallel Word Deserializer

This block takes a serial bit stream, one bit per clock, and rebuilds parallel words of `WORD_W` bits (ten by default). It does not use one long shift-in register. A select state alternates on every bit and steers even-positioned bits into one half-width branch and odd-positioned bits into the other. Each branch therefore fills at half the bit rate. When the final odd bit of a word arrives, the two halves are interleaved into a registered word, and a one-clock strobe marks it valid.

Word alignment is set by reset. The first bit sampled after reset is released becomes bit 0 of the first word, and every word after that follows back to back with no gap. The phase select and the slot counter are kept in three copies by default. A bitwise majority vote drives the logic and feeds each copy's next state, so an upset in one copy is masked at once and repaired on the next clock.

Top module: `oe_deser`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `word_out` is all zeros and `word_valid` is 0.
- R2: The bit sampled on the k-th rising edge of a word (k counted from 0, where the first edge after reset is k = 0 of the first word) appears at `word_out[k]`.
- R3: Even word positions (0, 2, 4, …) are collected by the even branch and odd positions by the odd branch. The select alternates on every clock. A stream of 0 on even positions and 1 on odd positions yields `word_out` = 10'h2AA, and the opposite stream yields 10'h155.
- R4: `word_valid` is high for exactly one clock, once every `WORD_W` clocks, and is visible just after the edge that samples the last bit of a word.
- R5: After reset, `word_valid` stays low until the edge that samples the `WORD_W`-th bit.
- R6: `word_out` changes only on the edge that raises `word_valid`. Between strobes it holds the last word.
- R7: Words that follow each other without gaps are each delivered intact. No bit is lost or duplicated at a word boundary.
- R8: A reset asserted in the middle of a word discards the partial word. The next bit after release becomes bit 0 of a new word.
- R9: With `TMR_EN`=1, the phase and slot state is held in three voted copies. Corrupting any one copy for a clock changes neither the word contents nor the strobe timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; one serial bit sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also sets word alignment |
| ser_in | input | 1 | Serial data bit |
| word_out | output | WORD_W | Registered parallel word, bit 0 received first |
| word_valid | output | 1 | One-clock strobe marking a new word on `word_out` |

## Verification
The bench builds the block with its defaults: `WORD_W`=10 and `TMR_EN`=1. At these values the five-slot counter wraps within every word, the interleave covers both a full even half and a full odd half, and the triple-copy path exists. That last point lets the bench overwrite one copy of the phase and slot state in mid-word and show that the output is unaffected. The single-copy variant chosen by `TMR_EN`=0 is not elaborated by this bench.

// File: rtl/deser_pkg.sv
package deser_pkg;

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } phase_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/ctl_cell.sv
module ctl_cell #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= d;
   end

   assign q = st_q;

endmodule

// File: rtl/deser_ctl.sv
module deser_ctl
   import deser_pkg::*;
#(
   parameter  int HALF   = 5,
   parameter  int TMR_EN = 1,
   localparam int SLOT_W = (HALF > 1) ? $clog2(HALF) : 1,
   localparam int ST_W   = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output phase_e            phase,
   output logic [SLOT_W-1:0] slot,
   output logic              done
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(HALF - 1);

   logic [ST_W-1:0]   st_v;
   logic [ST_W-1:0]   st_nxt;
   logic              sel_v;
   logic [SLOT_W-1:0] slot_v;

   assign sel_v  = st_v[ST_W-1];
   assign slot_v = st_v[SLOT_W-1:0];

   always_comb begin
      if (!sel_v) begin
         st_nxt = {1'b1, slot_v};
      end else if (slot_v == LAST) begin
         st_nxt = {1'b0, {SLOT_W{1'b0}}};
      end else begin
         st_nxt = {1'b0, slot_v + 1'b1};
      end
   end

   generate
      if (TMR_EN != 0) begin : g_tmr
         logic [ST_W-1:0] rep_q [3];
         for (genvar r = 0; r < 3; r++) begin : g_rep
            ctl_cell #(.W(ST_W)) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .d     (st_nxt),
               .q     (rep_q[r])
            );
         end
         for (genvar b = 0; b < ST_W; b++) begin : g_vote
            assign st_v[b] = maj3(rep_q[0][b], rep_q[1][b], rep_q[2][b]);
         end
      end else begin : g_single
         ctl_cell #(.W(ST_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (st_nxt),
            .q     (st_v)
         );
      end
   endgenerate

   assign phase = sel_v ? PH_ODD : PH_EVEN;
   assign slot  = slot_v;
   assign done  = sel_v && (slot_v == LAST);

endmodule

// File: rtl/half_branch.sv
module half_branch #(
   parameter int HALF   = 5,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic              bit_in,
   output logic [HALF-1:0]   q,
   output logic [HALF-1:0]   nxt
);

   logic [HALF-1:0] half_q;

   always_comb begin
      nxt = half_q;
      for (int i = 0; i < HALF; i++) begin
         if (wr_en && (slot == SLOT_W'(i))) nxt[i] = bit_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= nxt;
   end

   assign q = half_q;

endmodule

// File: rtl/oe_deser.sv
module oe_deser
   import deser_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int TMR_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);

   localparam int HALF   = WORD_W / 2;
   localparam int SLOT_W = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if ((WORD_W % 2) != 0 || WORD_W < 2) begin : g_bad_width
         $error("oe_deser: WORD_W must be even and at least 2");
      end
      if (TMR_EN != 0 && TMR_EN != 1) begin : g_bad_tmr
         $error("oe_deser: TMR_EN must be 0 or 1");
      end
   endgenerate

   phase_e            phase_v;
   logic [SLOT_W-1:0] slot_v;
   logic              done_v;
   logic [HALF-1:0]   even_q;
   logic [HALF-1:0]   even_nxt;
   logic [HALF-1:0]   odd_q;
   logic [HALF-1:0]   odd_nxt;
   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] word_q;
   logic              valid_q;

   deser_ctl #(.HALF(HALF), .TMR_EN(TMR_EN)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase_v),
      .slot  (slot_v),
      .done  (done_v)
   );

   half_branch #(.HALF(HALF), .SLOT_W(SLOT_W)) u_even (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (phase_v == PH_EVEN),
      .slot   (slot_v),
      .bit_in (ser_in),
      .q      (even_q),
      .nxt    (even_nxt)
   );

   half_branch #(.HALF(HALF), .SLOT_W(SLOT_W)) u_odd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (phase_v == PH_ODD),
      .slot   (slot_v),
      .bit_in (ser_in),
      .q      (odd_q),
      .nxt    (odd_nxt)
   );

   generate
      for (genvar j = 0; j < HALF; j++) begin : g_merge
         assign merged[2*j]   = even_q[j];
         assign merged[2*j+1] = odd_nxt[j];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= done_v;
         if (done_v) word_q <= merged;
      end
   end

   assign word_out   = word_q;
   assign word_valid = valid_q;

endmodule

// File: rtl/oe_deser_chk.sv
module oe_deser_chk #(
   parameter int WORD_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_valid,
   input logic [WORD_W-1:0] word_out,
   input logic              phase_v
);

   localparam int CW = $clog2(WORD_W + 2);

   logic [CW-1:0] since;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (word_valid)                   since <= CW'(1);
         else if (since < CW'(WORD_W + 1)) since <= since + 1'b1;
      end
   end

   AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (since == CW'(WORD_W))); // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R4
   AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (since < CW'(WORD_W)) |-> !word_valid); // R5
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(word_valid) |-> $stable(word_out)); // R6
   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (phase_v != $past(phase_v))); // R3

endmodule

bind oe_deser oe_deser_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (word_valid),
   .word_out   (word_out),
   .phase_v    (phase_v)
);

// File: tb/oe_deser_bench.sv
`timescale 1ns/1ps
module oe_deser_bench;

   localparam int WORD_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ser_in = 1'b0;
   logic [WORD_W-1:0] word_out;
   logic              word_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [WORD_W-1:0] held_word = '0;

   always #2.5 clk = ~clk;

   oe_deser #(.WORD_W(WORD_W), .TMR_EN(1)) u_oe_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_in     (ser_in),
      .word_out   (word_out),
      .word_valid (word_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // drive one bit, return at the negedge after the sampling edge
   task automatic send_bit(input logic b);
      ser_in = b;
      @(negedge clk);
   endtask

   task automatic push_word(input logic [WORD_W-1:0] w, input string req);
      for (int i = 0; i < WORD_W; i++) begin
         send_bit(w[i]);
         if (i < WORD_W - 1) begin
            chk(word_valid == 1'b0, {req, " R4 R5 valid low mid-word"}, 32'(word_valid), 0);
            chk(word_out == held_word, {req, " R6 word held"}, 32'(word_out), 32'(held_word));
         end else begin
            chk(word_valid == 1'b1, {req, " R4 valid strobe"}, 32'(word_valid), 1);
            chk(word_out == w, {req, " R2 word content"}, 32'(word_out), 32'(w));
         end
      end
      held_word = w;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      ser_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(word_out == '0, "R1 word zero in reset", 32'(word_out), 0);
      chk(word_valid == 1'b0, "R1 valid low in reset", 32'(word_valid), 0);
      rst_n = 1'b1;
      held_word = '0;
   endtask

   task automatic t_first_word();
      t_reset();
      push_word(10'h2C5, "R2 R5 first word");
      send_bit(1'b0);
      chk(word_valid == 1'b0, "R4 strobe one clock", 32'(word_valid), 0);
      chk(word_out == 10'h2C5, "R6 hold after strobe", 32'(word_out), 32'h2C5);
   endtask

   task automatic t_parity();
      t_reset();
      push_word(10'h2AA, "R3 odd ones");
      push_word(10'h155, "R3 even ones");
   endtask

   task automatic t_back_to_back();
      t_reset();
      push_word(10'h3FF, "R7 word a");
      push_word(10'h000, "R7 word b");
      push_word(10'h1B7, "R7 word c");
      push_word(10'h248, "R7 word d");
   endtask

   task automatic t_midreset();
      t_reset();
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(word_out == '0, "R8 R1 word cleared", 32'(word_out), 0);
      chk(word_valid == 1'b0, "R8 R1 valid cleared", 32'(word_valid), 0);
      rst_n = 1'b1;
      held_word = '0;
      push_word(10'h0F3, "R8 realigned");
   endtask

   task automatic t_upset();
      t_reset();
      push_word(10'h19C, "R9 before upset");
      for (int i = 0; i < 3; i++) begin
         send_bit(1'b1);
         chk(word_valid == 1'b0, "R9 no strobe pre-upset", 32'(word_valid), 0);
      end
      force u_oe_deser.u_ctl.g_tmr.g_rep[1].u_cell.st_q = 4'hF;
      send_bit(1'b0);
      release u_oe_deser.u_ctl.g_tmr.g_rep[1].u_cell.st_q;
      chk(word_valid == 1'b0, "R9 no strobe during upset", 32'(word_valid), 0);
      for (int i = 4; i < WORD_W; i++) begin
         send_bit(1'(i % 3 == 0));
         if (i < WORD_W - 1)
            chk(word_valid == 1'b0, "R9 no early strobe", 32'(word_valid), 0);
      end
      // bits: 1,1,1,0, then i%3==0 for i=4..9 -> 0,0,1,0,0,1
      chk(word_valid == 1'b1, "R9 strobe on time", 32'(word_valid), 1);
      chk(word_out == 10'h247, "R9 word intact", 32'(word_out), 32'h247);
      held_word = 10'h247;
      push_word(10'h2D1, "R9 after upset");
   endtask

   initial begin
      @(negedge clk);
      t_first_word();
      t_parity();
      t_back_to_back();
      t_midreset();
      t_upset();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule